// File: doc/BRIEF.md
# Byte-Addressed Memory with Console Channel

This block is the single storage for a small 32-bit core, holding both code and data. It has one word read port and one word write port. Both take byte addresses, so a word may start at any byte offset. Bytes are stored little-endian: the byte at the lowest address forms bits 7:0 of the word. At reset the array is loaded from a parameter image, and every byte past the end of the image is cleared to zero.

One fixed address is not part of the array. It maps onto a byte-wide console. A word read at that address takes one byte from the console input stream and returns it zero-extended to 32 bits. A word write at that address sends bits 7:0 of the write data to the console output stream and leaves the array unchanged.

Both console streams use valid/ready handshakes. An access to the console address waits until its stream is ready. Any other access completes in the cycle it is presented. An access that would run past the last byte of the array raises an error flag, completes, and changes nothing.

Top module: `bytemem_console`

## Requirements
- R1: After reset, array byte i holds INIT_IMAGE[8i+7:8i] for i < INIT_BYTES, and every byte from INIT_BYTES to MEM_BYTES-1 reads as zero.
- R2: A read at address A returns byte A+k of the array in rd_data[8k+7:8k], for k = 0..3 (little-endian).
- R3: Any byte address A with A <= MEM_BYTES-4 is a legal array access, whether or not A is a multiple of four.
- R4: An array write changes the four bytes A..A+3 on the clock edge where wr_req is high. A read in a later cycle returns the new bytes, and a read in the same cycle returns the old ones.
- R5: A read at CON_ADDR raises cin_ready. rd_ack then equals cin_valid, and rd_data equals {24'b0, cin_data}.
- R6: A write at CON_ADDR raises cout_valid with cout_data = wr_data[7:0] and wr_ack = cout_ready, and it leaves all array bytes unchanged.
- R7: A read or write at an address other than CON_ADDR with A > MEM_BYTES-4 raises its error flag (rd_err or wr_err) and its ack in the same cycle. Such a read returns zero, and such a write leaves the array unchanged.
- R8: A read or write at a non-console address is acknowledged in the cycle it is requested. Without a request there is no ack, no error flag, and no console handshake signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the image |
| rd_req | input | 1 | Read request |
| rd_addr | input | 32 | Read byte address |
| rd_data | output | 32 | Read word, little-endian |
| rd_ack | output | 1 | Read completes this cycle |
| rd_err | output | 1 | Read address runs past the array |
| wr_req | input | 1 | Write request |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write word, little-endian |
| wr_ack | output | 1 | Write completes this cycle |
| wr_err | output | 1 | Write address runs past the array |
| cin_valid | input | 1 | Console input byte available |
| cin_data | input | 8 | Console input byte |
| cin_ready | output | 1 | Console input byte consumed |
| cout_valid | output | 1 | Console output byte offered |
| cout_data | output | 8 | Console output byte |
| cout_ready | input | 1 | Console output byte accepted |

## Verification
The bench builds the block with MEM_BYTES = 64, INIT_BYTES = 6 and a six-byte image. With 64 bytes the top boundary can be reached in a few cycles, so accesses at offsets 60, 61 and 63 test the error rule right at its edge. A six-byte image ends inside the second word, so one read sees preloaded and zero-filled bytes together. The random phase mixes console handshakes that stall and ones that go through, and it overlaps reads and writes in the same cycle at nearby unaligned addresses.

// File: rtl/bytemem_console.sv
module bytemem_console #(
  parameter int          MEM_BYTES  = 512,
  parameter logic [31:0] CON_ADDR   = 32'h1000_0000,
  parameter int          INIT_BYTES = 8,
  parameter logic [8*INIT_BYTES-1:0] INIT_IMAGE = 64'h0000_0013_0010_0093
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [31:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_ack,
  output logic        rd_err,
  input  logic        wr_req,
  input  logic [31:0] wr_addr,
  input  logic [31:0] wr_data,
  output logic        wr_ack,
  output logic        wr_err,
  input  logic        cin_valid,
  input  logic [7:0]  cin_data,
  output logic        cin_ready,
  output logic        cout_valid,
  output logic [7:0]  cout_data,
  input  logic        cout_ready
);
  localparam int          AW       = $clog2(MEM_BYTES);
  localparam logic [31:0] LAST_OK  = 32'(MEM_BYTES - 4);

  logic [7:0] mem [MEM_BYTES];

  function automatic logic [7:0] image_byte(input int i);
    if (i < INIT_BYTES) return INIT_IMAGE[8*i +: 8];
    return 8'h00;
  endfunction

  logic rd_con, wr_con, rd_ok, wr_ok;
  logic [AW-1:0] ra, wa;

  assign rd_con = rd_req && (rd_addr == CON_ADDR);
  assign wr_con = wr_req && (wr_addr == CON_ADDR);
  assign rd_ok  = rd_req && !rd_con && (rd_addr <= LAST_OK);
  assign wr_ok  = wr_req && !wr_con && (wr_addr <= LAST_OK);
  assign ra     = rd_addr[AW-1:0];
  assign wa     = wr_addr[AW-1:0];

  assign rd_err     = rd_req && !rd_con && !rd_ok;
  assign wr_err     = wr_req && !wr_con && !wr_ok;
  assign rd_ack     = rd_con ? cin_valid : rd_req;
  assign wr_ack     = wr_con ? cout_ready : wr_req;
  assign cin_ready  = rd_con;
  assign cout_valid = wr_con;
  assign cout_data  = wr_data[7:0];

  always_comb begin
    rd_data = '0;
    if (rd_con) begin
      rd_data = {24'h0, cin_data};
    end else if (rd_ok) begin
      for (int k = 0; k < 4; k++) rd_data[8*k +: 8] = mem[ra + AW'(k)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= image_byte(i);
    end else if (wr_ok) begin
      for (int k = 0; k < 4; k++) mem[wa + AW'(k)] <= wr_data[8*k +: 8];
    end
  end
endmodule

module bytemem_console_chk #(
  parameter int          MEM_BYTES = 512,
  parameter logic [31:0] CON_ADDR  = 32'h1000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic [31:0] rd_data,
  input logic        rd_ack,
  input logic        rd_err,
  input logic        wr_req,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        wr_ack,
  input logic        wr_err,
  input logic        cin_valid,
  input logic        cout_ready
);
  localparam logic [31:0] LAST_OK = 32'(MEM_BYTES - 4);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd_req && $past(wr_req) && $past(wr_addr) != CON_ADDR &&
     $past(wr_addr) <= LAST_OK && rd_addr == $past(wr_addr))
    |-> rd_data == $past(wr_data)); // R4
  AST_CON_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == CON_ADDR) |-> (rd_data[31:8] == 24'h0 && rd_ack == cin_valid && !rd_err)); // R5
  AST_CON_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr == CON_ADDR) |-> (wr_ack == cout_ready && !wr_err)); // R6
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == 32'h0 && rd_ack)); // R7
  AST_ERR_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (wr_ack && wr_addr > LAST_OK)); // R7
  AST_ARRAY_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req && rd_addr != CON_ADDR) |-> rd_ack) and (!rd_req |-> !rd_ack && !rd_err)); // R8
endmodule

bind bytemem_console bytemem_console_chk #(.MEM_BYTES(MEM_BYTES), .CON_ADDR(CON_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
  .rd_ack(rd_ack), .rd_err(rd_err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ack(wr_ack), .wr_err(wr_err), .cin_valid(cin_valid), .cout_ready(cout_ready));

// File: tb/bytemem_console_tb.sv
module bytemem_console_tb;
  localparam int          MB   = 64;
  localparam int          NI   = 6;
  localparam logic [47:0] IMG  = 48'hA1B2_C3D4_E5F6;
  localparam logic [31:0] CON  = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  logic rd_req = 0, wr_req = 0, cin_valid = 0, cout_ready = 0;
  logic [31:0] rd_addr = 0, wr_addr = 0, wr_data = 0;
  logic [7:0]  cin_data = 0;
  logic [31:0] rd_data;
  logic rd_ack, rd_err, wr_ack, wr_err, cin_ready, cout_valid;
  logic [7:0] cout_data;

  int checks = 0, fails = 0;
  bit done = 0;
  byte unsigned model [MB];

  always #5 clk = ~clk;

  bytemem_console #(.MEM_BYTES(MB), .CON_ADDR(CON), .INIT_BYTES(NI), .INIT_IMAGE(IMG)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ack(rd_ack), .rd_err(rd_err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .cin_valid(cin_valid), .cin_data(cin_data),
    .cin_ready(cin_ready), .cout_valid(cout_valid), .cout_data(cout_data), .cout_ready(cout_ready));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit rq, input logic [31:0] ra, input bit wq,
                      input logic [31:0] wa, input logic [31:0] wd, input bit cv,
                      input logic [7:0] cd, input bit cr);
    logic [31:0] exp_d;
    bit rcon, wcon, rin, win;
    @(negedge clk);
    rd_req = rq; rd_addr = ra; wr_req = wq; wr_addr = wa; wr_data = wd;
    cin_valid = cv; cin_data = cd; cout_ready = cr;
    #2;
    rcon = rq && ra == CON; wcon = wq && wa == CON;
    rin = ra <= MB - 4; win = wa <= MB - 4;
    exp_d = 0;
    if (rcon) exp_d = {24'h0, cd};
    else if (rq && rin) for (int k = 0; k < 4; k++) exp_d[8*k +: 8] = model[ra + k];
    chk(tag, "rd_ack", rd_ack, rcon ? cv : rq);
    chk(tag, "rd_err", rd_err, rq && !rcon && !rin);
    chk(tag, "wr_ack", wr_ack, wcon ? cr : wq);
    chk(tag, "wr_err", wr_err, wq && !wcon && !win);
    chk(tag, "cin_ready", cin_ready, rcon);
    chk(tag, "cout_valid", cout_valid, wcon);
    if (rq) chk(tag, "rd_data", rd_data, exp_d);
    if (wcon) chk(tag, "cout_data", cout_data, wd[7:0]);
    @(posedge clk);
    if (wq && !wcon && win) for (int k = 0; k < 4; k++) model[wa + k] = wd[8*k +: 8];
  endtask

  initial begin
    for (int i = 0; i < MB; i++) model[i] = (i < NI) ? IMG[8*i +: 8] : 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset image and zero fill; R2 little-endian; R3 unaligned
    for (int a = 0; a <= MB - 4; a++) step("R1", 1, a, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 3, 0, 0, 0, 0, 0, 0);
    // R4 write then read; same-cycle read sees old
    step("R4", 1, 5, 1, 5, 32'hDEAD_BEEF, 0, 0, 0);
    step("R4", 1, 5, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 4, 1, 7, 32'h1122_3344, 0, 0, 0);
    step("R4", 1, 4, 0, 0, 0, 0, 0, 0);
    // R5 console read stall and transfer
    step("R5", 1, CON, 0, 0, 0, 0, 8'h55, 0);
    step("R5", 1, CON, 0, 0, 0, 1, 8'hA7, 0);
    // R6 console write stall, transfer, array untouched
    step("R6", 0, 0, 1, CON, 32'h0000_0041, 0, 0, 0);
    step("R6", 0, 0, 1, CON, 32'hFFFF_FF42, 0, 0, 1);
    for (int a = 0; a <= MB - 4; a += 4) step("R6", 1, a, 0, 0, 0, 0, 0, 0);
    // R7 boundary errors
    step("R7", 1, MB - 4, 1, MB - 4, 32'hCAFE_F00D, 0, 0, 0);
    step("R7", 1, MB - 3, 1, MB - 3, 32'h0BAD_0BAD, 0, 0, 0);
    step("R7", 1, MB - 1, 1, MB + 100, 32'h0BAD_0BAD, 0, 0, 0);
    step("R7", 1, MB - 4, 0, 0, 0, 0, 0, 0);
    // R8 idle
    step("R8", 0, 0, 0, 0, 0, 1, 8'h11, 1);
    for (int n = 0; n < 2000; n++) begin
      int unsigned sel;
      logic [31:0] ra, wa;
      sel = $urandom % 8;
      ra = (sel == 0) ? CON : (sel == 1) ? MB - 4 + ($urandom % 6) : $urandom % (MB - 3);
      sel = $urandom % 8;
      wa = (sel == 0) ? CON : (sel == 1) ? MB - 4 + ($urandom % 6) : $urandom % (MB - 3);
      step("R8", $urandom % 2, ra, $urandom % 2, wa, $urandom, $urandom % 2, $urandom, $urandom % 2);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule